// File: doc/BRIEF.md
# I2C Slave Engine with Arbitration-Loss Takeover

This block is the target side of an I2C bus port. It watches the SCL and SDA lines through synchronizers, finds START and STOP conditions, collects the first byte after each START and compares its upper seven bits with a programmed own address. It also accepts the general call (all-zero address, write direction). Once addressed, it receives or transmits data words whose bit count is set by a 3-bit length field. It acknowledges the address and every received word by pulling SDA low during the acknowledge clock. As a transmitter, it records the acknowledge bit that the bus master returns.

After every event the host has to handle, the engine pulses an interrupt, drops an active-low pending flag and holds SCL low. The clock stays stretched until the host reads the data buffer, writes it, or writes a release strobe.

A master that shares the port can report a lost arbitration through a single input. The engine then sets a sticky arbitration-lost flag and keeps following the bus as a slave. It raises an interrupt at the end of the word in progress even when its own address was not selected.

Top module: `i2c_slave_al`

## Requirements
- R1: After reset, pend_n is 1, irq is 0, neither bus line is driven, and all status flags are 0. A STOP (SDA rising while SCL is high) clears the arb-lost, transmitter, addressed and general-call flags.
- R2: When the address byte after a START has its upper seven bits equal to own_addr, the engine drives SDA low during the 9th clock and sets st_aas. It sets st_trx to the direction bit (bit 0, 1 = read). When that clock falls, it pulses irq, drops pend_n and drives SCL low.
- R3: An address byte of 0x00 is a general call: it is acknowledged and sets both st_aas and st_ad0. The byte 0x01 (zero address with the read bit) is not acknowledged and sets no flag.
- R4: An address byte that matches neither case gets no acknowledge and raises no interrupt. The words that follow it leave rx_data, the status flags and SDA untouched until the next START.
- R5: While pend_n is 0, a pulse on host_rd, host_wr or host_release sets pend_n to 1 and stops driving SCL.
- R6: In receive mode, each word is word_bits_cfg bits long, with 0 meaning 8. The word is taken MSB first and placed right-aligned in rx_data with the upper bits zero. It is acknowledged, and an interrupt follows the falling edge of its 9th-position acknowledge clock.
- R7: In transmit mode, the word written through host_wdata is sent from bit n-1 down to bit 0, where n comes from word_bits_cfg. The master's acknowledge level is stored in st_lrb, and an interrupt follows the acknowledge clock.
- R8: If the host clears st_trx with host_clr_trx and then releases the stretch, the engine stops driving SDA. It drives SDA no more until the next START and raises no interrupt in that time.
- R9: A pulse on arb_lost sets st_al. The word in progress then ends with an interrupt even without an address match, and received data goes into rx_data. A matching address still sets st_aas and st_trx as in R2.
- R10: A START (SDA falling while SCL is high) or a STOP clears st_aas, st_ad0 and st_trx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low (stretch) |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Programmed slave address |
| word_bits_cfg | input | 3 | Bits per data word, 0 means 8 |
| arb_lost | input | 1 | Pulse from the shared master: arbitration lost |
| host_rd | input | 1 | Host read of the data buffer |
| host_wr | input | 1 | Host write of the data buffer |
| host_wdata | input | 8 | Data written by the host |
| host_release | input | 1 | Host writes 1 to the pending flag |
| host_clr_trx | input | 1 | Host clears the transmitter flag |
| rx_data | output | 8 | Data buffer contents |
| irq | output | 1 | One-cycle interrupt request |
| pend_n | output | 1 | Active-low service-pending flag |
| st_al | output | 1 | Arbitration lost |
| st_trx | output | 1 | Transmitter mode |
| st_aas | output | 1 | Addressed as slave |
| st_ad0 | output | 1 | General call received |
| st_lrb | output | 1 | Last acknowledge bit received from the master |

## Verification
If the phase or the bit counter holds a wrong value, the acknowledge lands on the wrong clock. The master then reads SDA high at the 9th bit, or sees data bits pulled low, within the word where the error occurred. A wrong address decision shows up at once in st_aas, st_ad0 and st_trx, and in the missing or extra stretch a few cycles after that word's acknowledge clock. Errors in the buffer or in the transmit shift register appear as wrong rx_data, or as wrong bits read off SDA, by the end of the same word.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    typedef struct packed {
        logic al;
        logic trx;
        logic aas;
        logic ad0;
        logic lrb;
    } status_t;

    // bits per word; a zero field selects a full byte
    function automatic logic [CNT_W-1:0] word_len(input logic [2:0] cfg);
        return (cfg == 3'd0) ? CNT_W'(DATA_W) : CNT_W'(cfg);
    endfunction

    function automatic logic [DATA_W-1:0] low_mask(input logic [CNT_W-1:0] n);
        return ~({DATA_W{1'b1}} << n);
    endfunction

    // move bit n-1 to the MSB so the shifter always sends from the top
    function automatic logic [DATA_W-1:0] tx_align(input logic [DATA_W-1:0] v,
                                                   input logic [CNT_W-1:0]  n);
        return v << (CNT_W'(DATA_W) - n);
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_cond_detect.sv
module i2cs_cond_detect
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.start = scl && scl_q && sda_q && !sda;
        ev.stop  = scl && scl_q && !sda_q && sda;
        ev.rise  = scl && !scl_q;
        ev.fall  = !scl && scl_q;
    end
endmodule

// File: rtl/i2c_slave_al.sv
module i2c_slave_al
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    input  logic [6:0] own_addr,
    input  logic [2:0] word_bits_cfg,
    input  logic       arb_lost,
    input  logic       host_rd,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    input  logic       host_release,
    input  logic       host_clr_trx,
    output logic [7:0] rx_data,
    output logic       irq,
    output logic       pend_n,
    output logic       st_al,
    output logic       st_trx,
    output logic       st_aas,
    output logic       st_ad0,
    output logic       st_lrb
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_line, syn_line;
    assign raw_line = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        i2cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk(clk), .rst(rst), .d(raw_line[g]), .q(syn_line[g])
        );
    end

    logic scl_s, sda_s;
    assign scl_s = syn_line[0];
    assign sda_s = syn_line[1];

    bus_ev_t ev;
    i2cs_cond_detect u_cond (
        .clk(clk), .rst(rst), .scl(scl_s), .sda(sda_s), .ev(ev)
    );

    phase_t              phase;
    status_t             st;
    logic [CNT_W-1:0]    cnt;
    logic [DATA_W-1:0]   shreg, dbuf;
    logic                sda_oe, stretch;

    logic [CNT_W-1:0]    n_bits;
    logic                addr_hit, gcall, host_touch;
    logic [DATA_W-1:0]   tx_word;

    assign n_bits     = word_len(word_bits_cfg);
    assign addr_hit   = (shreg[7:1] == own_addr);
    assign gcall      = (shreg == '0);
    assign host_touch = host_rd || host_wr || host_release;
    assign tx_word    = tx_align(host_wr ? host_wdata : dbuf, n_bits);

    always_ff @(posedge clk) begin
        irq <= 1'b0;
        if (rst) begin
            phase   <= PH_IDLE;
            st      <= '0;
            cnt     <= '0;
            shreg   <= '0;
            dbuf    <= '0;
            sda_oe  <= 1'b0;
            stretch <= 1'b0;
        end else begin
            if (arb_lost)     st.al  <= 1'b1;
            if (host_clr_trx) st.trx <= 1'b0;
            if (host_wr)      dbuf   <= host_wdata;

            if (ev.stop || ev.start) begin
                phase   <= ev.start ? PH_ADDR : PH_IDLE;
                cnt     <= '0;
                st.aas  <= 1'b0;
                st.ad0  <= 1'b0;
                st.trx  <= 1'b0;
                if (ev.stop) st.al <= 1'b0;
                sda_oe  <= 1'b0;
                stretch <= 1'b0;
            end else if (stretch) begin
                if (host_touch) begin
                    stretch <= 1'b0;
                    if (phase == PH_TX) begin
                        if (st.trx && !host_clr_trx) begin
                            shreg  <= tx_word;
                            sda_oe <= ~tx_word[DATA_W-1];
                            cnt    <= '0;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
            end else begin
                unique case (phase)
                    PH_ADDR, PH_RX: begin
                        if (ev.rise) begin
                            shreg <= {shreg[DATA_W-2:0], sda_s};
                            cnt   <= cnt + CNT_W'(1);
                        end else if (ev.fall && phase == PH_ADDR &&
                                     cnt == CNT_W'(DATA_W)) begin
                            phase <= PH_ADDR_ACK;
                            if (addr_hit || gcall) begin
                                st.aas <= 1'b1;
                                st.ad0 <= gcall && !addr_hit;
                                st.trx <= addr_hit && shreg[0];
                                sda_oe <= 1'b1;
                            end
                        end else if (ev.fall && phase == PH_RX && cnt == n_bits) begin
                            phase <= PH_RX_ACK;
                            if (st.aas || st.al) dbuf <= shreg & low_mask(n_bits);
                            if (st.aas) sda_oe <= 1'b1;
                        end
                    end
                    PH_ADDR_ACK, PH_RX_ACK: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            phase  <= (phase == PH_ADDR_ACK && st.trx) ? PH_TX : PH_RX;
                            if (st.aas || st.al) begin
                                irq     <= 1'b1;
                                stretch <= 1'b1;
                            end
                        end
                    end
                    PH_TX: begin
                        if (ev.fall) begin
                            if (cnt == n_bits - CNT_W'(1)) begin
                                sda_oe <= 1'b0;
                                phase  <= PH_TX_ACK;
                            end else begin
                                sda_oe <= ~shreg[DATA_W-2];
                                shreg  <= shreg << 1;
                                cnt    <= cnt + CNT_W'(1);
                            end
                        end
                    end
                    PH_TX_ACK: begin
                        if (ev.rise) st.lrb <= sda_s;
                        else if (ev.fall) begin
                            phase   <= PH_TX;
                            cnt     <= '0;
                            irq     <= 1'b1;
                            stretch <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign scl_drive_low = stretch;
    assign pend_n        = ~stretch;
    assign sda_drive_low = sda_oe;
    assign rx_data       = dbuf;
    assign st_al         = st.al;
    assign st_trx        = st.trx;
    assign st_aas        = st.aas;
    assign st_ad0        = st.ad0;
    assign st_lrb        = st.lrb;
endmodule

// File: rtl/i2c_slave_al_chk.sv
module i2c_slave_al_chk (
    input logic clk,
    input logic rst,
    input logic irq,
    input logic pend_n,
    input logic sda_drive_low,
    input logic host_rd,
    input logic host_wr,
    input logic host_release,
    input logic st_trx,
    input logic st_aas,
    input logic st_ad0
);
    // R2: an interrupt always comes with a pending service
    a_r2_irq_sets_pending: assert property (@(posedge clk) disable iff (rst)
        irq |-> !pend_n);

    // R2: SDA is free whenever the clock is held by the engine
    a_r2_sda_free_in_stretch: assert property (@(posedge clk) disable iff (rst)
        !pend_n |-> !sda_drive_low);

    // R2: transmitter mode only exists while addressed
    a_r2_trx_needs_aas: assert property (@(posedge clk) disable iff (rst)
        st_trx |-> st_aas);

    // R3: general call flag implies addressed
    a_r3_ad0_needs_aas: assert property (@(posedge clk) disable iff (rst)
        st_ad0 |-> st_aas);

    // R5: any host touch ends the stretch on the next cycle
    a_r5_host_release: assert property (@(posedge clk) disable iff (rst)
        (!pend_n && !irq && (host_rd || host_wr || host_release)) |=> pend_n);
endmodule

bind i2c_slave_al i2c_slave_al_chk u_chk (
    .clk(clk), .rst(rst), .irq(irq), .pend_n(pend_n),
    .sda_drive_low(sda_drive_low), .host_rd(host_rd), .host_wr(host_wr),
    .host_release(host_release), .st_trx(st_trx), .st_aas(st_aas),
    .st_ad0(st_ad0)
);

// File: tb/i2c_slave_al_test.sv
module i2c_slave_al_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_drive_low, sda_drive_low;
    logic bus_scl, bus_sda;
    logic [6:0] own_addr = 7'h3A;
    logic [2:0] word_bits_cfg = 3'd0;
    logic arb_lost = 0, host_rd = 0, host_wr = 0, host_release = 0, host_clr_trx = 0;
    logic [7:0] host_wdata = '0;
    logic [7:0] rx_data;
    logic irq, pend_n, st_al, st_trx, st_aas, st_ad0, st_lrb;

    assign bus_scl = scl_m & ~scl_drive_low;
    assign bus_sda = sda_m & ~sda_drive_low;

    i2c_slave_al uut (
        .clk(clk), .rst(rst), .scl_in(bus_scl), .sda_in(bus_sda),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .own_addr(own_addr), .word_bits_cfg(word_bits_cfg), .arb_lost(arb_lost),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_release(host_release), .host_clr_trx(host_clr_trx),
        .rx_data(rx_data), .irq(irq), .pend_n(pend_n), .st_al(st_al),
        .st_trx(st_trx), .st_aas(st_aas), .st_ad0(st_ad0), .st_lrb(st_lrb)
    );

    int checks = 0, errors = 0, irq_n = 0;
    always @(posedge clk) if (!rst && irq) irq_n++;

    // {cfg, data sent, expected buffer}
    localparam logic [18:0] RX_VEC [6] = '{
        {3'd0, 8'hA5, 8'hA5},
        {3'd1, 8'h01, 8'h01},
        {3'd3, 8'h05, 8'h05},
        {3'd7, 8'h7F, 8'h7F},
        {3'd4, 8'h0A, 8'h0A},
        {3'd0, 8'h00, 8'h00}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1; tick(1); sig = 1'b0; tick(2);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(8);
        sda_m = 1'b0; tick(8); scl_m = 1'b0; tick(8);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(4); scl_m = 1'b1; tick(8);
        sda_m = 1'b1; tick(8);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        sda_m = b; tick(4);
        scl_m = 1'b1;
        tick(1);
        while (!bus_scl) tick(1);
        tick(4); r = bus_sda; tick(4);
        scl_m = 1'b0; tick(8);
    endtask

    task automatic send_word(input int n, input logic [7:0] v, output logic ack);
        logic d;
        for (int i = n - 1; i >= 0; i--) clk_bit(v[i], d);
        clk_bit(1'b1, ack);
        tick(4);
    endtask

    task automatic read_word(input int n, input logic mack, output logic [7:0] v);
        logic d;
        v = '0;
        for (int i = n - 1; i >= 0; i--) begin
            clk_bit(1'b1, d);
            v[i] = d;
        end
        clk_bit(mack, d);
        tick(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v, prev;
        int base;
        tick(4); rst = 1'b0; tick(4);

        // R1 reset state
        chk("R1 pend_n", pend_n, 1);
        chk("R1 irq", irq, 0);
        chk("R1 drives", {scl_drive_low, sda_drive_low}, 0);
        chk("R1 status", {st_al, st_trx, st_aas, st_ad0, st_lrb}, 0);

        // R2 write address match
        bus_start;
        base = irq_n;
        send_word(8, {7'h3A, 1'b0}, ack);
        chk("R2 addr ack", ack, 0);
        chk("R2 irq", irq_n - base, 1);
        chk("R2 stretch", {pend_n, scl_drive_low}, 2'b01);
        chk("R2 flags aas/trx/ad0", {st_aas, st_trx, st_ad0}, 3'b100);
        pulse(host_release);
        chk("R5 release", {pend_n, scl_drive_low}, 2'b10);

        // R6 table of receive words
        for (int k = 0; k < 6; k++) begin
            word_bits_cfg = RX_VEC[k][18:16];
            base = irq_n;
            send_word((RX_VEC[k][18:16] == 0) ? 8 : int'(RX_VEC[k][18:16]),
                      RX_VEC[k][15:8], ack);
            chk("R6 word ack", ack, 0);
            chk("R6 word irq", irq_n - base, 1);
            chk("R6 rx_data", rx_data, RX_VEC[k][7:0]);
            pulse(host_rd);
            chk("R5 release on read", pend_n, 1);
        end
        word_bits_cfg = 3'd0;
        bus_stop;
        chk("R10 stop clears aas", st_aas, 0);

        // R4 address mismatch
        prev = rx_data;
        bus_start;
        base = irq_n;
        send_word(8, {7'h20, 1'b0}, ack);
        chk("R4 no ack", ack, 1);
        send_word(8, 8'h55, ack);
        chk("R4 data no ack", ack, 1);
        chk("R4 no irq", irq_n - base, 0);
        chk("R4 rx_data kept", rx_data, prev);
        chk("R4 flags", {st_aas, st_ad0, st_trx, pend_n}, 4'b0001);
        bus_stop;

        // R3 general call, R10 repeated start
        bus_start;
        send_word(8, 8'h00, ack);
        chk("R3 gc ack", ack, 0);
        chk("R3 gc flags", {st_aas, st_ad0}, 2'b11);
        pulse(host_release);
        bus_start;
        chk("R10 start clears", {st_aas, st_ad0}, 2'b00);
        base = irq_n;
        send_word(8, 8'h01, ack);
        chk("R3 gc read rejected", {ack, st_aas, st_ad0}, 3'b100);
        chk("R3 no irq", irq_n - base, 0);
        bus_stop;

        // R7 transmit
        bus_start;
        send_word(8, {7'h3A, 1'b1}, ack);
        chk("R2 read ack", ack, 0);
        chk("R2 trx", {st_aas, st_trx}, 2'b11);
        host_wdata = 8'hC3; pulse(host_wr);
        base = irq_n;
        read_word(8, 1'b0, v);
        chk("R7 byte", v, 8'hC3);
        chk("R7 lrb 0", st_lrb, 0);
        chk("R7 irq", irq_n - base, 1);
        word_bits_cfg = 3'd3;
        host_wdata = 8'h05; pulse(host_wr);
        read_word(3, 1'b1, v);
        chk("R7 3-bit word", v, 8'h05);
        chk("R7 lrb 1", st_lrb, 1);
        // R8 host hands the bus back
        pulse(host_clr_trx);
        pulse(host_release);
        chk("R8 sda released", {sda_drive_low, pend_n, st_trx}, 3'b010);
        base = irq_n;
        word_bits_cfg = 3'd0;
        read_word(8, 1'b1, v);
        chk("R8 no data driven", v, 8'hFF);
        chk("R8 no irq", irq_n - base, 0);
        bus_stop;

        // R9 arbitration lost, address not ours
        bus_start;
        pulse(arb_lost);
        chk("R9 al set", st_al, 1);
        base = irq_n;
        send_word(8, {7'h20, 1'b0}, ack);
        chk("R9 no ack", ack, 1);
        chk("R9 irq after address", irq_n - base, 1);
        chk("R9 aas clear", st_aas, 0);
        pulse(host_release);
        send_word(8, 8'h3C, ack);
        chk("R9 data irq", irq_n - base, 2);
        chk("R9 data captured", rx_data, 8'h3C);
        pulse(host_rd);
        bus_stop;
        chk("R1 stop clears al", st_al, 0);

        // R9 arbitration lost, address ours with read
        bus_start;
        pulse(arb_lost);
        send_word(8, {7'h3A, 1'b1}, ack);
        chk("R9 match ack", ack, 0);
        chk("R9 al/aas/trx", {st_al, st_aas, st_trx}, 3'b111);
        pulse(host_clr_trx);
        pulse(host_release);
        chk("R8 idle after clear", sda_drive_low, 0);
        bus_stop;
        chk("R1 final status", {st_al, st_aas, st_trx, st_ad0}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule